// File: doc/BRIEF.md
# Serial Flash Clock Divider and Gates

This block derives three clock enables for a serial flash controller from a parent clock enable. A source stage divides the parent by a pre-divide ratio. A main stage divides the source enable by a ratio taken from a sparse table. A half-rate stage divides the gated main enable by exactly two. The two ratio fields and two gate bits share one control register, which is written and read over a simple bus port.

Each gate bit is a disable: a 1 stops the matching enable. Both gates come out of reset set, so the main and half-rate enables stay quiet until software clears them. The source enable runs from reset. A parameter selects the source decode variant. The alternate variant can move the source stage to a second parent enable input, which has its own fixed divider. A new ratio or source selection is held back until the running output period ends, so no pulse is ever cut short.

Top module: `flash_clk_ctrl`

## Requirements
- R1: After reset the register reads 0x0311 in the standard variant and 0x0301 in the alternate variant. `main_en` and `half_en` stay low and `src_en` keeps running.
- R2: A read returns the last written main code in bits [2:0], the source code in bits [4:3], the main gate in bit 8 and the half gate in bit 9. Every other bit reads 0. Read data appears one cycle after `reg_rd`.
- R3: The main code in bits [2:0] sets the divide of `src_en`. Codes 1, 3, 5 and 7 divide by 2, 4, 6 and 8, so one `main_en` pulse follows every N `src_en` pulses.
- R4: Main codes 0, 2, 4 and 6 divide by 2.
- R5: In the standard variant the source code in bits [4:3] sets the divide of `parent_en`. Code 3 divides by 6, and codes 2, 1 and 0 divide by 5.
- R6: In the alternate variant, source code 0 divides `parent_en` by 5, code 1 divides it by 3, and code 3 divides it by 2. Code 2 divides `alt_parent_en` by ALT_DIV.
- R7: A 1 in bit 8 suppresses every `main_en` pulse. Because the half-rate stage counts gated main pulses, it also stops `half_en`.
- R8: A 1 in bit 9 suppresses `half_en` and leaves `main_en` running.
- R9: `half_en` pulses once for every two `main_en` pulses.
- R10: A new ratio or source selection takes effect only after the running output period completes. The period in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| parent_en | input | 1 | Parent clock enable for the source stage |
| alt_parent_en | input | 1 | Second parent enable, used by alternate source code 2 |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_rd | input | 1 | Read strobe for the control register |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Registered read data |
| src_en | output | 1 | Source clock enable |
| main_en | output | 1 | Gated main interface clock enable |
| half_en | output | 1 | Gated half-rate clock enable |

## Verification
A wrong count or a stale ratio inside a divider shows at the ports as a wrong gap between two pulses. It becomes visible within one output period: at most 48 cycles for `main_en` and 96 for `half_en` when the parent enable is always high. A wrong gate bit shows up as pulses inside a window that should be quiet. A reload applied at the wrong moment shows up as a short or long first period after a write. A corrupted register field shows on the next read, one cycle after the strobe.

// File: rtl/flash_clk_pkg.sv
package flash_clk_pkg;

  // Field positions: software and the decode depend on them.
  localparam int MAIN_LSB      = 0;
  localparam int MAIN_W        = 3;
  localparam int SRC_LSB       = 3;
  localparam int SRC_W         = 2;
  localparam int GATE_MAIN_BIT = 8;
  localparam int GATE_HALF_BIT = 9;
  localparam int MAX_FIXED_DIV = 8;

  typedef struct packed {
    logic              gate_half;
    logic              gate_main;
    logic [SRC_W-1:0]  src_code;
    logic [MAIN_W-1:0] main_code;
  } ctrl_t;

  // Odd codes give code+1; even codes fall back to divide by 2.
  function automatic int unsigned main_ratio(logic [MAIN_W-1:0] code);
    if (code[0]) return int'(code) + 1;
    return 2;
  endfunction

  function automatic int unsigned src_ratio(logic [SRC_W-1:0] code,
                                            bit alt_map,
                                            int unsigned alt_div);
    if (alt_map) begin
      case (code)
        2'd0:    return 5;
        2'd1:    return 3;
        2'd2:    return alt_div;
        default: return 2;
      endcase
    end
    if (code == 2'd3) return 6;
    return 5;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_clk_regs.sv
module flash_clk_regs
  import flash_clk_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter bit ALT_SRC_MAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output ctrl_t            fields_o
);

  localparam logic [SRC_W-1:0] SRC_RST = ALT_SRC_MAP ? 2'd0 : 2'd2;

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic [REG_W-1:0] packed_rd;

  always_comb begin
    ctrl_d.main_code = wdata[MAIN_LSB +: MAIN_W];
    ctrl_d.src_code  = wdata[SRC_LSB +: SRC_W];
    ctrl_d.gate_main = wdata[GATE_MAIN_BIT];
    ctrl_d.gate_half = wdata[GATE_HALF_BIT];
  end

  always_comb begin
    packed_rd                        = '0;
    packed_rd[MAIN_LSB +: MAIN_W]    = ctrl_q.main_code;
    packed_rd[SRC_LSB +: SRC_W]      = ctrl_q.src_code;
    packed_rd[GATE_MAIN_BIT]         = ctrl_q.gate_main;
    packed_rd[GATE_HALF_BIT]         = ctrl_q.gate_half;
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[GATE_MAIN_BIT-1:SRC_LSB+SRC_W],
                          wdata[REG_W-1:GATE_HALF_BIT+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q.main_code <= 3'd1;
      ctrl_q.src_code  <= SRC_RST;
      ctrl_q.gate_main <= 1'b1;
      ctrl_q.gate_half <= 1'b1;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= packed_rd;
  end

  assign fields_o = ctrl_q;

  AST_WRITE_STORED: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (fields_o.main_code == $past(wdata[2:0])) &&
              (fields_o.src_code  == $past(wdata[4:3])) &&
              (fields_o.gate_main == $past(wdata[8])) &&
              (fields_o.gate_half == $past(wdata[9]))); // R2

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en && !$past(rst) |=> $stable(fields_o)); // R2

endmodule

// File: rtl/flash_clk_divider.sv
module flash_clk_divider #(
  parameter int RATIO_W   = 4,
  parameter int RST_RATIO = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               gate_off_i,
  output logic               wrap_o,
  output logic               pulse_o
);

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               last;

  assign last   = (cnt_q == ratio_q - 1'b1);
  assign wrap_o = tick_i && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_W'(RST_RATIO);
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= wrap_o && !gate_off_i;
      if (tick_i) begin
        if (last) begin
          cnt_q   <= '0;
          ratio_q <= ratio_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q < ratio_q); // R10

  AST_RELOAD_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$past(wrap_o) && !$past(rst) |-> $stable(ratio_q)); // R10

  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(tick_i)); // R3

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    $past(gate_off_i) |-> !pulse_o); // R7

endmodule

// File: rtl/flash_clk_src.sv
module flash_clk_src
  import flash_clk_pkg::*;
#(
  parameter int RATIO_W     = 4,
  parameter bit ALT_SRC_MAP = 1'b0,
  parameter int ALT_DIV     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             parent_en_i,
  input  logic             alt_parent_en_i,
  input  logic [SRC_W-1:0] src_code_i,
  output logic             src_en_o
);

  logic               use_alt_q;
  logic               tick;
  logic               src_wrap;
  logic [RATIO_W-1:0] ratio_next;

  assign tick       = use_alt_q ? alt_parent_en_i : parent_en_i;
  assign ratio_next = RATIO_W'(src_ratio(src_code_i, ALT_SRC_MAP, ALT_DIV));

  flash_clk_divider #(
    .RATIO_W  (RATIO_W),
    .RST_RATIO(5)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .ratio_i   (ratio_next),
    .gate_off_i(1'b0),
    .wrap_o    (src_wrap),
    .pulse_o   (src_en_o)
  );

  generate
    if (ALT_SRC_MAP) begin : g_alt
      always_ff @(posedge clk) begin
        if (rst)           use_alt_q <= 1'b0;
        else if (src_wrap) use_alt_q <= (src_code_i == 2'd2);
      end

      AST_SEL_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$past(src_wrap) && !$past(rst) |-> $stable(use_alt_q)); // R6
    end else begin : g_std
      assign use_alt_q = 1'b0;
      logic unused_wrap;
      assign unused_wrap = src_wrap;
    end
  endgenerate

endmodule

// File: rtl/flash_clk_ctrl.sv
module flash_clk_ctrl
  import flash_clk_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter bit ALT_SRC_MAP = 1'b0,
  parameter int ALT_DIV     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             parent_en,
  input  logic             alt_parent_en,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             src_en,
  output logic             main_en,
  output logic             half_en
);

  localparam int MAX_RATIO = max2(MAX_FIXED_DIV, ALT_DIV);
  localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

  ctrl_t              ctrl;
  logic [RATIO_W-1:0] main_ratio_next;
  logic               main_wrap;
  logic               half_wrap;
  logic               unused_wraps;

  assign main_ratio_next = RATIO_W'(main_ratio(ctrl.main_code));
  assign unused_wraps    = main_wrap ^ half_wrap;

  flash_clk_regs #(
    .REG_W      (REG_W),
    .ALT_SRC_MAP(ALT_SRC_MAP)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr),
    .rd_en   (reg_rd),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .fields_o(ctrl)
  );

  flash_clk_src #(
    .RATIO_W    (RATIO_W),
    .ALT_SRC_MAP(ALT_SRC_MAP),
    .ALT_DIV    (ALT_DIV)
  ) u_src (
    .clk            (clk),
    .rst            (rst),
    .parent_en_i    (parent_en),
    .alt_parent_en_i(alt_parent_en),
    .src_code_i     (ctrl.src_code),
    .src_en_o       (src_en)
  );

  flash_clk_divider #(
    .RATIO_W  (RATIO_W),
    .RST_RATIO(2)
  ) u_main (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (src_en),
    .ratio_i   (main_ratio_next),
    .gate_off_i(ctrl.gate_main),
    .wrap_o    (main_wrap),
    .pulse_o   (main_en)
  );

  flash_clk_divider #(
    .RATIO_W  (RATIO_W),
    .RST_RATIO(2)
  ) u_half (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (main_en),
    .ratio_i   (RATIO_W'(2)),
    .gate_off_i(ctrl.gate_half),
    .wrap_o    (half_wrap),
    .pulse_o   (half_en)
  );

  AST_MAIN_AFTER_SRC: assert property (@(posedge clk) disable iff (rst)
    main_en |-> $past(src_en)); // R3

  AST_HALF_AFTER_MAIN: assert property (@(posedge clk) disable iff (rst)
    half_en |-> $past(main_en)); // R9

  AST_HALF_NOT_WITH_MAIN: assert property (@(posedge clk) disable iff (rst)
    half_en |-> !$past(half_en)); // R9

endmodule

// File: tb/flash_clk_ctrl_test.sv
`timescale 1ns/1ps
module flash_clk_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        parent_en = 1'b1;
  logic        alt_en = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, wr_a = 1'b0, rd_a = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, rdata_a;
  logic        src_en, main_en, half_en;
  logic        src_en_a, main_en_a, half_en_a;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int pushed = 0;
  int done   = 0;

  typedef struct {
    int    which;
    int    exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  flash_clk_ctrl uut (
    .clk(clk), .rst(rst), .parent_en(parent_en), .alt_parent_en(alt_en),
    .reg_wr(wr), .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata),
    .src_en(src_en), .main_en(main_en), .half_en(half_en));

  flash_clk_ctrl #(.ALT_SRC_MAP(1'b1), .ALT_DIV(4)) uut_alt (
    .clk(clk), .rst(rst), .parent_en(parent_en), .alt_parent_en(alt_en),
    .reg_wr(wr_a), .reg_rd(rd_a), .reg_wdata(wdata), .reg_rdata(rdata_a),
    .src_en(src_en_a), .main_en(main_en_a), .half_en(half_en_a));

  function automatic logic pick(int w);
    case (w)
      0:       return src_en;
      1:       return main_en;
      2:       return half_en;
      default: return src_en_a;
    endcase
  endfunction

  task automatic report(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops an expected gap and measures it between two pulses
  initial begin
    forever begin
      item_t it;
      int n;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      do @(negedge clk); while (!pick(it.which));
      n = 0;
      do begin @(negedge clk); n++; end while (!pick(it.which));
      report(n == it.exp, it.tag, n, it.exp);
      done++;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial forever begin @(negedge clk); alt_en = ~alt_en; end

  task automatic expect_gap(int which, int exp, string tag);
    item_t it;
    it.which = which; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    pushed++;
  endtask

  task automatic drain();
    wait (done == pushed);
  endtask

  task automatic write_reg(bit alt, logic [15:0] v);
    @(negedge clk);
    wdata = v;
    if (alt) wr_a = 1'b1; else wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wr_a = 1'b0;
  endtask

  task automatic check_read(bit alt, logic [15:0] exp, string tag);
    @(negedge clk);
    if (alt) rd_a = 1'b1; else rd = 1'b1;
    @(negedge clk);
    rd = 1'b0; rd_a = 1'b0;
    report((alt ? rdata_a : rdata) == exp, tag, int'(alt ? rdata_a : rdata), int'(exp));
  endtask

  task automatic settle();
    repeat (200) @(negedge clk);
  endtask

  task automatic quiet(int which, int cycles, string tag);
    int seen = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (pick(which)) seen++;
    end
    report(seen == 0, tag, seen, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_read(1'b0, 16'h0311, "R1 reset read");
    check_read(1'b1, 16'h0301, "R1 reset read alt");
    quiet(1, 120, "R1 main idle after reset");
    quiet(2, 120, "R1 half idle after reset");
    expect_gap(0, 5, "R1 R5 src runs at reset (code 2 /5)");
    drain();

    // gates open, src code 0, main code 1
    write_reg(1'b0, 16'h0001);
    check_read(1'b0, 16'h0001, "R2 readback 0x0001");
    settle();
    expect_gap(0, 5,  "R5 src code 0 /5");
    expect_gap(1, 10, "R3 main code 1 /2");
    expect_gap(2, 20, "R9 half of main");
    drain();

    write_reg(1'b0, 16'h001B);
    settle();
    expect_gap(0, 6,  "R5 src code 3 /6");
    expect_gap(1, 24, "R3 main code 3 /4");
    expect_gap(2, 48, "R9 half of main /4");
    drain();

    write_reg(1'b0, 16'h0017);
    settle();
    expect_gap(1, 40, "R3 main code 7 /8");
    drain();

    write_reg(1'b0, 16'h0015);
    settle();
    expect_gap(1, 30, "R3 main code 5 /6");
    drain();

    write_reg(1'b0, 16'h0014);
    settle();
    expect_gap(1, 10, "R4 main code 4 /2");
    drain();

    write_reg(1'b0, 16'h0010);
    settle();
    expect_gap(1, 10, "R4 main code 0 /2");
    drain();

    write_reg(1'b0, 16'h000A);
    settle();
    expect_gap(0, 5, "R5 src code 1 /5");
    drain();

    // R10 reload at period end
    write_reg(1'b0, 16'h0017);
    settle();
    expect_gap(1, 40, "R10 running period keeps old ratio");
    do @(negedge clk); while (!main_en);
    wdata = 16'h0011; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    expect_gap(1, 10, "R10 new ratio after period end");
    drain();

    // gates
    write_reg(1'b0, 16'h0211);
    check_read(1'b0, 16'h0211, "R2 readback half gate");
    settle();
    expect_gap(1, 10, "R8 main keeps running");
    drain();
    quiet(2, 200, "R8 half gated");

    write_reg(1'b0, 16'h0111);
    quiet(1, 200, "R7 main gated");
    quiet(2, 200, "R7 half stops with main");

    write_reg(1'b0, 16'hFFFF);
    check_read(1'b0, 16'h031F, "R2 unused bits read zero");

    // alternate variant
    write_reg(1'b1, 16'h0008);
    settle();
    expect_gap(3, 3, "R6 alt code 1 /3");
    drain();
    write_reg(1'b1, 16'h0010);
    settle();
    expect_gap(3, 8, "R6 alt code 2 alt parent /4");
    drain();
    write_reg(1'b1, 16'h0018);
    settle();
    expect_gap(3, 2, "R6 alt code 3 /2");
    drain();
    write_reg(1'b1, 16'h0000);
    settle();
    expect_gap(3, 5, "R6 alt code 0 /5");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule